// File: doc/BRIEF.md
# Carry-Pipelined Phase Accumulator

This block is the phase accumulator of a direct digital synthesizer meant for sample clocks near 393 MHz. It repeatedly adds a frequency tuning word to a wide phase register. The single output is the wrap carry of that register, and it serves as a synthesized square-wave clock. Its average rate is the tuning word divided by two to the accumulator width, times the clock rate. With 30 or more bits the resolution is about one part per billion.

A full-width adder cannot close timing at that rate. The accumulator is therefore cut into equal segments, and any leftover bits go to the top segment. A flip-flop sits on the carry between each segment and the next, so every segment runs one cycle behind the segment below it. The intermediate phase bits never form a coherent word. The top carry is still exactly the carry stream of a plain accumulator, delayed by a fixed number of cycles.

A tuning word is captured when the load strobe is high. Each segment's slice of the word is then delayed by that segment's lag, so all segments switch on the same accumulation step. Updates are expected to be rare, for example from a disciplined-oscillator loop.

Top module: `carry_pipe_dds`

## Requirements
- R1: A synchronous reset clears every segment, carry flop and the held tuning word. `carry_out` is 0 on every cycle that follows a clock edge with `rst` high.
- R2: `carry_out` equals the registered carry of an unpipelined accumulator of the same width, fed the same held word, delayed by SEGS-1 cycles, on every cycle.
- R3: Segments are WIDTH/SEGS bits wide (integer division), with the remainder bits added to the most significant segment. R2 holds when WIDTH is not a multiple of SEGS.
- R4: `ftw_in` is captured only on an edge where `ftw_load` is 1. Changes of `ftw_in` without the strobe have no effect on `carry_out`.
- R5: After a load, the new word is used from the next accumulation step in every segment. There is no mixed-word step, so R2 holds across back-to-back word changes.
- R6: Over any 2^WIDTH consecutive steps with one word F, `carry_out` is 1 on exactly F cycles.
- R7: With a held word of 0 the accumulator holds its value and `carry_out` stays 0.
- R8: WIDTH and SEGS are parameters. Their defaults are 32 and 4, so the width exceeds 30 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| ftw_in | input | WIDTH | Frequency tuning word |
| ftw_load | input | 1 | Capture strobe for `ftw_in` |
| carry_out | output | 1 | Delayed top-segment carry, the synthesized clock |

## Verification
A word presented with the strobe before edge e is held after e. It is first added on edge e+1, and that step's carry reaches `carry_out` after edge e+SEGS. The bench keeps a behavioural full-width accumulator updated on the same edges. It holds that model's carries in a shift history of depth SEGS-1. At each falling edge it compares `carry_out` with the oldest history entry. Rate counts start only after SEGS-1 pipeline-fill cycles following the load, so that every counted carry comes from the new word.

// File: rtl/dds_carry_pkg.sv
package dds_carry_pkg;
    // Width of segment idx: the floor share, and the top one takes the remainder.
    function automatic int seg_width(input int width, input int segs, input int idx);
        int base;
        base = width / segs;
        return (idx == segs - 1) ? (width - base * (segs - 1)) : base;
    endfunction

    function automatic int seg_lsb(input int width, input int segs, input int idx);
        return idx * (width / segs);
    endfunction
endpackage

// File: rtl/ftw_skew.sv
module ftw_skew #(
    parameter int W     = 8,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) stage[i] <= '0;
        end else begin
            stage[0] <= din;
            for (int i = 1; i < DEPTH; i++) stage[i] <= stage[i-1];
        end
    end

    assign dout = stage[DEPTH-1];
endmodule

// File: rtl/acc_segment.sv
module acc_segment #(
    parameter int SEG_W = 8,
    parameter int DELAY = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEG_W-1:0] ftw_slice,
    input  logic             carry_in,
    output logic             carry_q
);
    logic [SEG_W-1:0] ftw_use;
    logic [SEG_W-1:0] acc_q;
    logic [SEG_W:0]   sum;

    generate
        if (DELAY == 0) begin : g_direct
            assign ftw_use = ftw_slice;
        end else begin : g_skew
            ftw_skew #(.W(SEG_W), .DEPTH(DELAY)) u_skew (
                .clk  (clk),
                .rst  (rst),
                .din  (ftw_slice),
                .dout (ftw_use)
            );
        end
    endgenerate

    always_comb begin
        sum = {1'b0, acc_q} + {1'b0, ftw_use} + {{SEG_W{1'b0}}, carry_in};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            carry_q <= 1'b0;
        end else begin
            acc_q   <= sum[SEG_W-1:0];
            carry_q <= sum[SEG_W];
        end
    end

    // R1: reset empties this segment
    a_r1_seg_clear: assert property (@(posedge clk)
        rst |=> (acc_q == '0 && !carry_q));

    // R7: nothing added means nothing moves and no carry leaves
    a_r7_zero_step: assert property (@(posedge clk) disable iff (rst)
        (ftw_use == '0 && !carry_in) |=> (!carry_q && $stable(acc_q)));
endmodule

// File: rtl/carry_pipe_dds.sv
module carry_pipe_dds #(
    parameter int WIDTH = 32,
    parameter int SEGS  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] ftw_in,
    input  logic             ftw_load,
    output logic             carry_out
);
    import dds_carry_pkg::*;

    localparam int LATENCY = SEGS - 1;

    logic [WIDTH-1:0] ftw_q;
    logic [SEGS:0]    chain;

    always_ff @(posedge clk) begin
        if (rst)           ftw_q <= '0;
        else if (ftw_load) ftw_q <= ftw_in;
    end

    assign chain[0] = 1'b0;

    generate
        for (genvar k = 0; k < SEGS; k++) begin : g_seg
            localparam int SW  = seg_width(WIDTH, SEGS, k);
            localparam int LSB = seg_lsb(WIDTH, SEGS, k);
            acc_segment #(.SEG_W(SW), .DELAY(k)) u_seg (
                .clk       (clk),
                .rst       (rst),
                .ftw_slice (ftw_q[LSB +: SW]),
                .carry_in  (chain[k]),
                .carry_q   (chain[k+1])
            );
        end
    endgenerate

    assign carry_out = chain[SEGS];

    // R1: output low after any reset edge
    a_r1_reset_low: assert property (@(posedge clk)
        rst |=> !carry_out);

    // R4: strobe captures the word
    a_r4_load_capture: assert property (@(posedge clk) disable iff (rst)
        ftw_load |=> (ftw_q == $past(ftw_in)));

    // R4: without strobe the held word stays
    a_r4_hold_word: assert property (@(posedge clk) disable iff (rst)
        !ftw_load |=> $stable(ftw_q));

    initial begin
        a_r8_width: assert (WIDTH >= SEGS && SEGS >= 1 && LATENCY >= 0);
    end
endmodule

// File: tb/carry_pipe_dds_test.sv
module carry_pipe_dds_test;
    localparam int TW = 14;
    localparam int TS = 4;
    localparam int L  = TS - 1;
    localparam int PERIOD = 1 << TW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [TW-1:0] ftw_in = '0;
    logic          ftw_load = 1'b0;
    logic          carry_out;

    int checks = 0;
    int errors = 0;

    carry_pipe_dds #(.WIDTH(TW), .SEGS(TS)) uut (
        .clk       (clk),
        .rst       (rst),
        .ftw_in    (ftw_in),
        .ftw_load  (ftw_load),
        .carry_out (carry_out)
    );

    always #2 clk = ~clk;

    // Behavioural full-width accumulator and delay history
    logic [TW-1:0] ref_acc, ref_ftw;
    logic [TW:0]   ref_sum;
    logic [L:0]    hist;
    assign ref_sum = {1'b0, ref_acc} + {1'b0, ref_ftw};

    always @(posedge clk) begin
        if (rst) begin
            ref_acc <= '0;
            ref_ftw <= '0;
            hist    <= '0;
        end else begin
            ref_acc <= ref_sum[TW-1:0];
            if (ftw_load) ref_ftw <= ftw_in;
            hist <= {hist[L-1:0], ref_sum[TW]};
        end
    end

    task automatic check_val(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic load_word(input logic [TW-1:0] w);
        ftw_in   = w;
        ftw_load = 1'b1;
        @(negedge clk);
        ftw_load = 1'b0;
    endtask

    task automatic follow(input int n, input string tag);
        repeat (n) begin
            @(negedge clk);
            check_val(tag, int'(carry_out), int'(hist[L]));
        end
    endtask

    // Count carries over one full period of the word just loaded
    task automatic rate(input logic [TW-1:0] w, input logic [TW-1:0] noise, input string tag);
        int ones;
        ones = 0;
        load_word(w);
        ftw_in = noise;
        repeat (L) @(negedge clk);
        repeat (PERIOD) begin
            @(negedge clk);
            ones += int'(carry_out);
        end
        check_val(tag, ones, int'(w));
    endtask

    initial begin
        repeat (3) begin
            @(negedge clk);
            check_val("R1 reset", int'(carry_out), 0);
        end
        rst = 1'b0;
        follow(20, "R7 idle after reset");

        // Corner words: all ones, one, low-segment fill, cross-segment ripple
        load_word(14'h3FFF); follow(300, "R2 all-ones");
        load_word(14'h0001); follow(300, "R2 one");
        load_word(14'h0007); follow(300, "R3 low fill");
        load_word(14'h01FF); follow(300, "R3 ripple");
        load_word(14'h2000); follow(300, "R2 top bit");

        // Sweep of words, back to back loads
        for (int i = 0; i < 40; i++) begin
            load_word(TW'((i * 14'h01A5 + 3) & (PERIOD - 1)));
            follow(400, "R5 sweep");
        end
        for (int i = 0; i < 8; i++) begin
            load_word(TW'(14'h3FF0 + i));
            follow(3, "R5 rapid reload");
        end
        follow(100, "R5 rapid settle");

        // Inputs move without strobe
        load_word(14'h0ABC);
        for (int i = 0; i < 30; i++) begin
            ftw_in = TW'(i * 14'h0333);
            follow(10, "R4 no strobe");
        end

        // Zero word
        load_word(14'h0000);
        follow(L, "R7 drain");
        begin
            int ones;
            ones = 0;
            repeat (300) begin
                @(negedge clk);
                ones += int'(carry_out);
            end
            check_val("R7 zero word", ones, 0);
        end

        rate(14'h0003, 14'h3FFF, "R6/R4 rate 3");
        rate(14'h02AB, 14'h1234, "R6 rate 0x2AB");

        // Reset in mid-run
        load_word(14'h3FFD); follow(50, "R2 pre-reset");
        rst = 1'b1;
        repeat (4) begin
            @(negedge clk);
            check_val("R1 mid reset", int'(carry_out), 0);
        end
        rst = 1'b0;
        follow(30, "R1 post reset idle");
        load_word(14'h1F0F); follow(300, "R2 post reset");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors + 1);
        $finish;
    end
endmodule